// File: doc/BRIEF.md
# Cascadable Synchronous BCD Decade Counter

This block is one decimal digit of a synchronous counter. It holds a 4-bit binary-coded decimal value that steps 0, 1, … 9 and then wraps to 0. Every change to the stored value happens on the rising clock edge. The operation for each edge is chosen from the input levels sampled at that edge. In priority order the operations are: synchronous clear, synchronous parallel load, count, and hold.

Two enable inputs control counting. The local enable `en_count` lets a single digit run or stop. The chain enable `en_chain` also qualifies the combinational carry output, which is high while the digit shows 9.

To build an n-digit counter, drive each digit's `en_chain` from the carry of the digit below it, and drive every `en_count` from one common run signal. The whole chain then advances on the same edge with no extra gating. Codes 10 to 15 can be reached by a load or by power-up. They step back into the decimal sequence within two enabled counts.

Top module: `bcd_decade_cnt`

## Requirements
- R1: While `clr_n` is low at a rising edge, the count becomes 0 after that edge, whatever `load_n`, `din`, `en_count` and `en_chain` are.
- R2: While `clr_n` is high and `load_n` is low at a rising edge, the count takes the value of `din` after that edge, whatever the enables are. Codes 10 to 15 are taken as they are.
- R3: While `clr_n` and `load_n` are high and `en_count` and `en_chain` are both high at a rising edge, a legal count advances by one in binary order (`q[3]` is the MSB), and 9 goes to 0.
- R4: While `clr_n` and `load_n` are high and either enable is low at a rising edge, the count keeps its value.
- R5: `carry_out` is high exactly when `en_chain` is high and `q` equals 9 (4'b1001). It follows its inputs without waiting for a clock, and `en_count` has no effect on it.
- R6: When the count is enabled, the illegal codes step as follows: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2. Any code from 10 to 15 therefore reaches 0 to 9 within two enabled counts.
- R7: Changes on `load_n`, `en_count` or `en_chain` between rising edges do not alter the stored count. Only the levels present at the edge matter.
- R8: In a chain where each stage's `en_chain` is driven by the previous stage's `carry_out` and all `en_count` pins share one signal, two stages count 00 through 99 and then wrap to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_count | input | 1 | Local count enable |
| en_chain | input | 1 | Chain count enable; also qualifies `carry_out` |
| din | input | 4 | Parallel load value |
| q | output | 4 | Current count |
| carry_out | output | 1 | Terminal-count carry toward the next digit |

## Verification
Several behaviours are checked on every clocked cycle by assertions: the value that follows a clear, a load, a hold or an enabled count; the 9-to-0 wrap; the single-step return from each odd illegal code; and the carry, which may only be high at 9 while the chain enable is high. Other behaviours are shown only by the bench scenarios:
- the full 0-to-99 roll-over of a two-digit chain;
- immunity to control pulses that start and end between edges;
- the order in which overlapping clear, load and count requests are resolved;
- the reference sequence: preset to 7, count through the wrap, then stop.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] bcd_t;

    // Operation selected for the coming edge, highest priority last
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    typedef struct packed {
        bcd_t value;
    } cnt_state_t;

endpackage

// File: rtl/bcd_op_decode.sv
module bcd_op_decode
    import bcd_cnt_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_count,
    input  logic    en_chain,
    output cnt_op_e op
);

    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_count && en_chain) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

    // R1: clear request overrides every other control
    always_comb begin
        if (!clr_n) begin
            clear_wins_chk: assert (op == OP_CLEAR);
        end
    end

endmodule

// File: rtl/bcd_successor.sv
module bcd_successor
    import bcd_cnt_pkg::*;
(
    input  bcd_t cur,
    output bcd_t nxt,
    output logic illegal
);

    localparam bcd_t LAST_LEGAL = bcd_t'(DIGIT_MAX);

    assign illegal = (cur > LAST_LEGAL);

    always_comb begin
        if (cur == LAST_LEGAL) begin
            nxt = '0;
        end else if (!illegal) begin
            nxt = cur + bcd_t'(1);
        end else begin
            unique case (cur)
                4'd10:   nxt = 4'd11;
                4'd11:   nxt = 4'd6;
                4'd12:   nxt = 4'd13;
                4'd13:   nxt = 4'd4;
                4'd14:   nxt = 4'd15;
                default: nxt = 4'd2;
            endcase
        end
    end

    // R6: an odd illegal code always lands on a legal digit
    always_comb begin
        if (illegal && cur[0]) begin
            odd_illegal_exit_chk: assert (nxt <= LAST_LEGAL);
        end
    end

endmodule

// File: rtl/bcd_carry.sv
module bcd_carry
    import bcd_cnt_pkg::*;
(
    input  bcd_t value,
    input  logic en_chain,
    output logic carry
);

    localparam bcd_t TERMINAL = bcd_t'(DIGIT_MAX);

    logic at_terminal;

    assign at_terminal = (value == TERMINAL);
    assign carry       = en_chain & at_terminal;

endmodule

// File: rtl/bcd_decade_cnt.sv
module bcd_decade_cnt
    import bcd_cnt_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic       load_n,
    input  logic       en_count,
    input  logic       en_chain,
    input  logic [3:0] din,
    output logic [3:0] q,
    output logic       carry_out
);

    cnt_state_t st_d, st_q;
    cnt_op_e    op;
    bcd_t       succ;
    logic       succ_illegal;

    bcd_op_decode u_decode (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .en_count (en_count),
        .en_chain (en_chain),
        .op       (op)
    );

    bcd_successor u_succ (
        .cur     (st_q.value),
        .nxt     (succ),
        .illegal (succ_illegal)
    );

    bcd_carry u_carry (
        .value    (st_q.value),
        .en_chain (en_chain),
        .carry    (carry_out)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.value = '0;
            OP_LOAD:  st_d.value = din;
            OP_COUNT: st_d.value = succ;
            default:  st_d.value = st_q.value;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.value;

    // ---------------------------------------------------------------
    // Checks. armed_q is set by the first clear so that no property
    // looks at the undefined count before it.
    // ---------------------------------------------------------------
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) armed_q <= 1'b1;
    end

    // R1
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> (q == 4'd0));

    // R2
    load_takes_din_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !load_n) |=> (q == $past(din)));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && load_n && !(en_count && en_chain)) |=> $stable(q));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && load_n && en_count && en_chain && q < 4'd9)
        |=> (q == $past(q) + 4'd1));

    // R3
    wrap_nine_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && load_n && en_count && en_chain && q == 4'd9) |=> (q == 4'd0));

    // R6
    recover_odd_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && load_n && en_count && en_chain && q > 4'd9 && q[0])
        |=> (q <= 4'd9));

    // R6
    recover_even_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && load_n && en_count && en_chain && q > 4'd9 && !q[0])
        |=> (q == $past(q) + 4'd1));

    // R5
    carry_only_at_nine_chk: assert property (@(posedge clk) disable iff (!armed_q)
        carry_out |-> (q == 4'd9 && en_chain));

endmodule

// File: tb/bcd_decade_cnt_test.sv
`timescale 1ns/1ps
module bcd_decade_cnt_test;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       load_n = 1'b1;
    logic       en_count = 1'b0;
    logic       en_chain = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] q;
    logic       carry_out;
    logic       hi_load_n = 1'b1;
    logic [3:0] q_hi;
    logic       carry_hi;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    bcd_decade_cnt uut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_count(en_count),
        .en_chain(en_chain), .din(din), .q(q), .carry_out(carry_out)
    );

    // upper digit of a two-stage chain
    bcd_decade_cnt uut_hi (
        .clk(clk), .clr_n(clr_n), .load_n(hi_load_n), .en_count(en_count),
        .en_chain(carry_out), .din(4'd0), .q(q_hi), .carry_out(carry_hi)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int next_code(input int c);
        case (c)
            9:  return 0;
            10: return 11;
            11: return 6;
            12: return 13;
            13: return 4;
            14: return 15;
            15: return 2;
            default: return c + 1;
        endcase
    endfunction

    task automatic load_value(input int v);
        load_n = 1'b0; din = 4'(v);
        step();
        load_n = 1'b1;
    endtask

    task automatic t_clear();
        clr_n = 1'b0; load_n = 1'b0; din = 4'd5; en_count = 1'b1; en_chain = 1'b1;
        step();
        check(q == 4'd0, "R1 clear beats load/enables", q, 0);
        check(q_hi == 4'd0, "R1 clear upper digit", q_hi, 0);
        clr_n = 1'b1; load_n = 1'b1; en_count = 1'b0; en_chain = 1'b0;
    endtask

    task automatic t_reference_seq();
        int exp_seq[6] = '{8, 9, 0, 1, 2, 3};
        load_value(7);
        check(q == 4'd7, "R2 preset seven", q, 7);
        en_count = 1'b1; en_chain = 1'b1;
        foreach (exp_seq[i]) begin
            step();
            check(q == 4'(exp_seq[i]), "R3 reference count", q, exp_seq[i]);
            check(carry_out == (exp_seq[i] == 9), "R5 carry pulse at nine",
                  carry_out, exp_seq[i] == 9);
        end
        en_count = 1'b0;
        step();
        check(q == 4'd3, "R4 inhibit with en_count low", q, 3);
        en_count = 1'b1; en_chain = 1'b0;
        step();
        check(q == 4'd3, "R4 inhibit with en_chain low", q, 3);
        en_count = 1'b0;
    endtask

    task automatic t_load_priority();
        en_count = 1'b1; en_chain = 1'b1;
        load_value(6);
        check(q == 4'd6, "R2 load beats count", q, 6);
        en_count = 1'b0; en_chain = 1'b0;
    endtask

    task automatic t_carry();
        load_value(9);
        en_chain = 1'b1; en_count = 1'b0;
        #1;
        check(carry_out == 1'b1, "R5 carry with en_count low", carry_out, 1);
        en_count = 1'b1; #0.5;
        check(carry_out == 1'b1, "R5 carry with en_count high", carry_out, 1);
        en_count = 1'b0;
        en_chain = 1'b0; #0.5;
        check(carry_out == 1'b0, "R5 carry gated by en_chain", carry_out, 0);
        load_value(8);
        en_chain = 1'b1; #0.5;
        check(carry_out == 1'b0, "R5 no carry at eight", carry_out, 0);
        en_chain = 1'b0;
    endtask

    task automatic t_illegal();
        for (int code = 10; code <= 15; code++) begin
            int e1, e2;
            load_value(code);
            check(q == 4'(code), "R2 illegal code loaded as is", q, code);
            e1 = next_code(code);
            e2 = next_code(e1);
            en_count = 1'b1; en_chain = 1'b1;
            step();
            check(q == 4'(e1), "R6 first illegal step", q, e1);
            step();
            check(q == 4'(e2), "R6 second step", q, e2);
            check(q <= 4'd9, "R6 legal within two counts", q, 9);
            en_count = 1'b0; en_chain = 1'b0;
        end
    endtask

    task automatic t_between_edges();
        load_value(4);
        en_count = 1'b0; en_chain = 1'b0;
        #0.5;
        load_n = 1'b0; din = 4'd8; en_count = 1'b1; en_chain = 1'b1;
        #0.5;
        load_n = 1'b1; en_count = 1'b0; en_chain = 1'b0;
        step();
        check(q == 4'd4, "R7 pulses between edges ignored", q, 4);
    endtask

    task automatic t_cascade();
        clr_n = 1'b0;
        step();
        clr_n = 1'b1;
        en_count = 1'b1; en_chain = 1'b1;
        for (int i = 1; i <= 100; i++) begin
            step();
            check(q == 4'(i % 10), "R8 low digit", q, i % 10);
            check(q_hi == 4'((i / 10) % 10), "R8 high digit", q_hi, (i / 10) % 10);
            if (i == 99) check(carry_hi == 1'b1, "R8 chain carry at 99", carry_hi, 1);
        end
        en_count = 1'b0; en_chain = 1'b0;
    endtask

    initial begin
        #1;
        t_clear();
        t_reference_seq();
        t_load_priority();
        t_carry();
        t_illegal();
        t_between_edges();
        t_cascade();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule